// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash bus and decides when an embedded program or erase operation inside the flash has finished. After a `start` pulse it issues reads through a simple request/acknowledge port, one after another. It compares a designated toggle bit (bit 6 of the data word) between two successive reads. While the flash is busy that bit flips on every read; once the operation is over it holds still.

When the toggle bit is still flipping, the poller looks at a timeout flag (bit 5) in the newer of the two words. If the flag is clear it simply polls another pair. If the flag is set, the toggle bit may have stopped at the very moment the flag rose. The poller therefore takes one mandatory confirmation pair of reads before it declares a failure. A parameterised ceiling on ordinary poll pairs turns a stuck bus into an error instead of a hang.

The outcome is reported as a single-cycle `done_o` pulse together with a sticky `error_o` bit. The error bit keeps its value in idle and is cleared only when the next operation is accepted.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rd_req_o`, `busy_o`, `done_o` and `error_o` are all low.
- R2: A `start_i` pulse seen in idle launches polling, and at least two reads are acknowledged before any result is reported.
- R3: When bit 6 is equal in the two words of a poll pair, the poller finishes without error and issues no further read.
- R4: When bit 6 differs within a poll pair and bit 5 of the second word is 0, the poller issues another poll pair.
- R5: When bit 6 differs within a poll pair and bit 5 of the second word is 1, exactly one confirmation pair is read. Equal bit 6 values in that pair give a result without error.
- R6: When bit 6 still differs within the confirmation pair, the poller finishes with `error_o` high. No further read is issued.
- R7: When `MAX_POLL_PAIRS` (non-zero) ordinary poll pairs have all shown toggling with bit 5 clear, the poller finishes with `error_o` high after exactly 2*`MAX_POLL_PAIRS` reads.
- R8: `rd_req_o` stays high from cycle to cycle until `rd_ack_i` is seen. The word is captured on the acknowledge edge, and any following request belongs to a new read. `rd_req_o` is never high while `busy_o` is low.
- R9: `done_o` is high for exactly one cycle per operation, and `busy_o` is low in that cycle. `busy_o` is high in every cycle from the cycle after `start_i` is accepted until that cycle.
- R10: `error_o` takes its result in the `done_o` cycle and keeps it while idle. It falls to 0 in the cycle after the next `start_i` is accepted.
- R11: `start_i` pulses while an operation is in progress are ignored and change neither the number of reads nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a completion poll (accepted only in idle) |
| rd_req_o | output | 1 | Read request to the bus, held until acknowledged |
| rd_ack_i | input | 1 | Read acknowledge; `rd_data_i` is valid in this cycle |
| rd_data_i | input | DATA_W | Data word returned by the flash |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Sticky failure status of the last poll |

## Verification
The bench aims at the confirmation path. It checks that a pair showing a set timeout flag is followed by exactly one more pair and never by further ordinary polling. A design that skipped the confirmation would report false failures. A design that looped back into polling would show a read count that is too high. The poll-pair ceiling is exercised at its exact boundary, where an off-by-one shows up as two reads too many or too few. Varying acknowledge latencies, back-to-back requests and stray start pulses check that a request is never dropped before its acknowledge and that a second start cannot restart a running poll. The bench also checks that the sticky error survives idle cycles and clears one cycle after the next start.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD1    = 3'd1,
    ST_RD2    = 3'd2,
    ST_CHECK  = 3'd3,
    ST_CONF1  = 3'd4,
    ST_CONF2  = 3'd5,
    ST_FINISH = 3'd6
  } tpoll_state_e;

  // The status bit flipped between two reads of the flash.
  function automatic logic bit_toggled(input logic older, input logic newer);
    return older ^ newer;
  endfunction

  // True when the pair being evaluated is the last one allowed.
  // A limit of zero means polling is unbounded.
  function automatic logic limit_reached(input int unsigned pairs_incl_this,
                                         input int unsigned max_pairs);
    return (max_pairs != 0) && (pairs_incl_this >= max_pairs);
  endfunction

  // A state issues a bus read.
  function automatic logic is_read_state(input tpoll_state_e s);
    return (s == ST_RD1) || (s == ST_RD2) || (s == ST_CONF1) || (s == ST_CONF2);
  endfunction

endpackage

// File: rtl/tpoll_rd_port.sv
module tpoll_rd_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              load_second,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              ack_evt,
  output logic [DATA_W-1:0] word_first,
  output logic [DATA_W-1:0] word_second
);

  assign ack_evt = req & rd_ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_first  <= '0;
      word_second <= '0;
    end else if (ack_evt) begin
      if (load_second) word_second <= rd_data_i;
      else             word_first  <= rd_data_i;
    end
  end

endmodule

// File: rtl/tpoll_pair_cnt.sv
module tpoll_pair_cnt
  import tpoll_pkg::*;
#(
  parameter int MAX_POLL_PAIRS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last_pair
);

  generate
    if (MAX_POLL_PAIRS == 0) begin : g_unbounded
      assign last_pair = 1'b0;
    end else begin : g_bounded
      localparam int CNT_W = $clog2(MAX_POLL_PAIRS + 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (inc) cnt_q <= cnt_q + 1'b1;
      end

      assign last_pair = limit_reached(int'(cnt_q) + 1, MAX_POLL_PAIRS);
    end
  endgenerate

endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
  import tpoll_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int TOGGLE_BIT     = 6,
  parameter int TIMEOUT_BIT    = 5,
  parameter int MAX_POLL_PAIRS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              rd_req_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o
);

  tpoll_state_e st_q, st_d;
  logic err_q;

  logic              ack_evt;
  logic [DATA_W-1:0] word_first, word_second;
  logic              last_pair;

  // Named internal events
  logic start_accept;
  logic pair_toggled;
  logic pair_timeout;
  logic conf_toggled;
  logic poll_again;
  logic fail_set;

  assign start_accept = (st_q == ST_IDLE) && start_i;
  assign rd_req_o     = is_read_state(st_q);

  tpoll_rd_port #(.DATA_W(DATA_W)) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (rd_req_o),
    .load_second (st_q == ST_RD2),
    .rd_ack_i    (rd_ack_i),
    .rd_data_i   (rd_data_i),
    .ack_evt     (ack_evt),
    .word_first  (word_first),
    .word_second (word_second)
  );

  assign pair_toggled = bit_toggled(word_first[TOGGLE_BIT], word_second[TOGGLE_BIT]);
  assign pair_timeout = word_second[TIMEOUT_BIT];
  assign conf_toggled = bit_toggled(word_first[TOGGLE_BIT], rd_data_i[TOGGLE_BIT]);
  assign poll_again   = (st_q == ST_CHECK) && pair_toggled && !pair_timeout;

  tpoll_pair_cnt #(.MAX_POLL_PAIRS(MAX_POLL_PAIRS)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (start_accept),
    .inc       (poll_again),
    .last_pair (last_pair)
  );

  assign fail_set = (poll_again && last_pair) ||
                    ((st_q == ST_CONF2) && ack_evt && conf_toggled);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (start_i) st_d = ST_RD1;
      ST_RD1:    if (ack_evt) st_d = ST_RD2;
      ST_RD2:    if (ack_evt) st_d = ST_CHECK;
      ST_CHECK: begin
        if (!pair_toggled)     st_d = ST_FINISH;
        else if (pair_timeout) st_d = ST_CONF1;
        else if (last_pair)    st_d = ST_FINISH;
        else                   st_d = ST_RD1;
      end
      // The confirmation reuses the first capture slot for its first word.
      ST_CONF1:  if (ack_evt) st_d = ST_CONF2;
      ST_CONF2:  if (ack_evt) st_d = ST_FINISH;
      ST_FINISH: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start_accept)  err_q <= 1'b0;
      else if (fail_set) err_q <= 1'b1;
    end
  end

  assign busy_o  = (st_q != ST_IDLE) && (st_q != ST_FINISH);
  assign done_o  = (st_q == ST_FINISH);
  assign error_o = err_q;

  // ---------------- assertions ----------------
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> rd_req_o)
    else $error("R8 request dropped before acknowledge");

  a_r8_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !rd_req_o)
    else $error("R8 request while not busy");

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o)
    else $error("R9 done longer than one cycle");

  a_r9_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> busy_o)
    else $error("R9 busy not raised after start");

  a_r10_err_changes: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(error_o) |-> (done_o || $past(start_accept)))
    else $error("R10 error changed outside done or start");

  a_r6_conf_then_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CONF2 && ack_evt) |=> done_o)
    else $error("R6 confirmation not followed by finish");

endmodule

// File: tb/toggle_poll_ctrl_test.sv
module toggle_poll_ctrl_test;

  localparam int MAXP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       rd_ack_i = 1'b0;
  logic [7:0] rd_data_i = 8'h00;
  logic       rd_req_o, busy_o, done_o, error_o;

  int tests = 0;
  int fails = 0;

  toggle_poll_ctrl #(.DATA_W(8), .TOGGLE_BIT(6), .TIMEOUT_BIT(5),
                     .MAX_POLL_PAIRS(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_req_o(rd_req_o),
    .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .busy_o(busy_o),
    .done_o(done_o), .error_o(error_o));

  always #10 clk = ~clk;  // 50 MHz

  // stimulus words and bookkeeping
  logic [7:0] plan_q[$];
  logic [7:0] feed_q[$];
  int  latency  = 0;
  int  wait_cnt = 0;
  int  reads    = 0;
  bit  running  = 0;
  bit  prev_req = 0;
  bit  prev_done = 0;
  bit  mon_on   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] mk(input bit t6, input bit t5);
    logic [7:0] w;
    w = 8'($urandom);
    w[6] = t6;
    w[5] = t5;
    return w;
  endfunction

  // Behavioural expectation from the requirements
  task automatic expect_of(output int nreads, output bit fail);
    int i = 0;
    int pairs = 0;
    nreads = 0; fail = 0;
    forever begin
      if (plan_q[i][6] == plan_q[i+1][6]) begin i += 2; break; end
      if (plan_q[i+1][5]) begin
        fail = (plan_q[i+2][6] != plan_q[i+3][6]);
        i += 4; break;
      end
      i += 2; pairs++;
      if (pairs >= MAXP) begin fail = 1; break; end
    end
    nreads = i;
  endtask

  // Per-cycle monitor and bus responder
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (prev_req && !rd_ack_i) chk(rd_req_o == 1'b1, "R8", rd_req_o, 1);
        if (!busy_o) chk(rd_req_o == 1'b0, "R8", rd_req_o, 0);
        if (prev_done) chk(done_o == 1'b0, "R9", done_o, 0);
        if (running && !done_o) chk(busy_o == 1'b1, "R9", busy_o, 1);
        if (done_o) begin
          chk(busy_o == 1'b0, "R9", busy_o, 0);
          running = 0;
        end
      end
      prev_req  = rd_req_o;
      prev_done = done_o;
      if (rd_ack_i) begin
        rd_ack_i = 1'b0;
      end else if (rd_req_o) begin
        if (wait_cnt >= latency) begin
          rd_ack_i = 1'b1;
          rd_data_i = (feed_q.size() > 0) ? feed_q.pop_front() : mk(reads[0], 1'b0);
          reads++;
          wait_cnt = 0;
        end else wait_cnt++;
      end
    end
  end

  task automatic run_case(input string req, input int lat, input bit stray_start);
    int exp_reads;
    bit exp_fail;
    int guard = 0;
    expect_of(exp_reads, exp_fail);
    feed_q = plan_q;
    latency = lat;
    reads = 0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    running = 1;
    chk(error_o == 1'b0, "R10", error_o, 0);   // cleared after start accepted
    if (stray_start) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1;  // R11: must be ignored
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 2000, "watchdog", guard, 0);
    chk(error_o == exp_fail, req, error_o, exp_fail);
    chk(reads == exp_reads, req, reads, exp_reads);
    chk(reads >= 2, "R2", reads, 2);
    repeat (3) @(negedge clk);
    chk(reads == exp_reads, req, reads, exp_reads);  // no extra reads after done
    chk(error_o == exp_fail, "R10", error_o, exp_fail);  // sticky in idle
    plan_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({rd_req_o, busy_o, done_o, error_o} == 4'b0, "R1", {rd_req_o, busy_o, done_o, error_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({rd_req_o, busy_o, done_o, error_o} == 4'b0, "R1", {rd_req_o, busy_o, done_o, error_o}, 0);
    mon_on = 1;

    // R3: stable at once
    plan_q = '{mk(1,0), mk(1,0)};
    run_case("R3", 0, 0);
    // R4: one toggling pair then stable
    plan_q = '{mk(0,0), mk(1,0), mk(1,0), mk(1,0)};
    run_case("R4", 1, 0);
    // R5: timeout flag, confirmation stable
    plan_q = '{mk(0,0), mk(1,1), mk(0,1), mk(0,1)};
    run_case("R5", 0, 0);
    // R6: confirmation still toggles
    plan_q = '{mk(1,0), mk(0,1), mk(1,1), mk(0,1)};
    run_case("R6", 2, 0);
    // R10: error clears on a good run that follows
    plan_q = '{mk(0,0), mk(0,0)};
    run_case("R10", 0, 0);
    // R7: pair ceiling reached
    for (int k = 0; k < MAXP; k++) begin
      plan_q.push_back(mk(0,0));
      plan_q.push_back(mk(1,0));
    end
    run_case("R7", 0, 0);
    // R4/R5: several pairs then confirmation succeeds, slow bus
    plan_q = '{mk(0,0), mk(1,0), mk(1,0), mk(0,0), mk(0,0), mk(1,1), mk(1,0), mk(1,0)};
    run_case("R5", 3, 0);
    // R11: stray start during polling
    plan_q = '{mk(0,0), mk(1,0), mk(0,0), mk(1,0), mk(1,0), mk(0,1), mk(1,1), mk(0,1)};
    run_case("R11", 1, 1);
    // R7 boundary: last allowed pair is stable
    for (int k = 0; k < MAXP - 1; k++) begin
      plan_q.push_back(mk(1,0));
      plan_q.push_back(mk(0,0));
    end
    plan_q.push_back(mk(1,0));
    plan_q.push_back(mk(1,0));
    run_case("R7", 0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // Global watchdog
  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule